// File: doc/BRIEF.md
# Parallel Flash Program and Erase Sequencer

This block sits on the host side of an asynchronous parallel NOR flash bus. A client hands it one request at a time: an operation (program one location, erase one sector, or erase the whole chip), a target address, the data for a program, and a choice of completion algorithm. The sequencer then drives the unlock and command write cycles onto the bus. Every bus cycle is built from clock counts set by parameters.

Once the last command write is issued, the sequencer reads the status at the target address until it can decide the outcome. There are two ways to poll. Data polling compares status bit 7 with the bit the finished operation will leave behind. Toggle polling watches whether bit 6 keeps flipping between two reads that follow each other. Bit 5 is the device's time-limit flag. Because the device can change bit 5 in the same moment it finishes, a set bit 5 is never taken as a failure at once; it always leads to one more confirming look. A failed operation ends with a reset command to the device. Every request ends in exactly one single-cycle `done` or `fail` pulse.

Top module: `flash_seq`

## Requirements
- R1: `req_ready` is high only while the sequencer is idle. A request is taken when `req_valid` and `req_ready` are both high at a clock edge. `req_valid` while busy has no effect on the bus or on the outcome.
- R2: With `req_op`=0 (program), the write cycles are, as (address, data): (UNLK_A, AAh), (UNLK_B, 55h), (UNLK_A, A0h), then (request address, request data).
- R3: With `req_op`=2 or 3 (chip erase), the write cycles are (UNLK_A, AAh), (UNLK_B, 55h), (UNLK_A, 80h), (UNLK_A, AAh), (UNLK_B, 55h), (UNLK_A, 10h).
- R4: With `req_op`=1 (sector erase), the first five writes match R3, and the last write is (request address, 30h).
- R5: In each write cycle, `f_ce_n` is low and `f_oe_n` is high while `f_we_n` is low. `f_we_n` stays low for T_WL clocks. Address and write data do not change while `f_we_n` is low or at its rising edge. Write data is never driven while `f_oe_n` is low.
- R6: With `req_poll`=0 (data polling), status reads go to the request address. The operation passes on the first read whose bit 7 equals the expected bit: bit 7 of the request data for a program, 1 for an erase.
- R7: In data polling, a read with a mismatching bit 7 and bit 5 set causes exactly one more read. That read passes if bit 7 matches and fails otherwise.
- R8: With `req_poll`=1 (toggle polling), status is read in pairs. The operation passes when bit 6 is equal in both reads of a pair.
- R9: In toggle polling, a toggling pair whose second read has bit 5 set causes exactly one more pair. That pair passes if bit 6 is steady and fails otherwise.
- R10: On failure, one extra write of (address 0, F0h) follows the last status read, and `fail` is raised only after that write.
- R11: Each accepted request produces exactly one pulse, one clock wide, on either `done` or `fail`, never both. `req_ready` is high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_op | input | 2 | 0 program, 1 sector erase, 2 or 3 chip erase |
| req_poll | input | 1 | 0 data polling, 1 toggle polling |
| req_addr | input | AW | Target address (program location or sector) |
| req_data | input | DW | Program data |
| done | output | 1 | One-clock pass pulse |
| fail | output | 1 | One-clock failure pulse |
| f_addr | output | AW | Flash address bus |
| f_dq_o | output | DW | Flash write data |
| f_dq_oe | output | 1 | Write data drive enable |
| f_dq_i | input | DW | Flash read data |
| f_ce_n | output | 1 | Chip enable, active low |
| f_we_n | output | 1 | Write enable, active low |
| f_oe_n | output | 1 | Output enable, active low |

## Verification
The checker watches the bus framing on every clock: chip enable and output enable around each write strobe, the strobe width, address and data stability up to and across the strobe's rising edge, and the exclusion of driving data during a read. It also checks that the bus is quiet while idle and that the result pulses are single and exclusive. Several things can only come from the bench's scenarios, because they depend on a modelled device answering with a chosen status history: the exact order of command writes for each operation, the number of status reads each algorithm spends, the extra confirming read or pair after the time-limit flag, and the reset write that comes before a failure.

// File: rtl/flash_seq.sv
module flash_seq #(
  parameter int AW = 22,
  parameter int DW = 8,
  parameter int T_WL = 2,
  parameter int T_RD = 2,
  parameter int T_GAP = 1,
  parameter logic [AW-1:0] UNLK_A = AW'('h555),
  parameter logic [AW-1:0] UNLK_B = AW'('h2AA)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic          req_poll,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          done,
  output logic          fail,
  output logic [AW-1:0] f_addr,
  output logic [DW-1:0] f_dq_o,
  output logic          f_dq_oe,
  input  logic [DW-1:0] f_dq_i,
  output logic          f_ce_n,
  output logic          f_we_n,
  output logic          f_oe_n
);
  localparam int MAXT = (T_WL > T_RD) ? ((T_WL > T_GAP) ? T_WL : T_GAP)
                                      : ((T_RD > T_GAP) ? T_RD : T_GAP);
  localparam int CW = $clog2(MAXT + 1);

  typedef enum logic [1:0] {S_IDLE, S_WR, S_RD, S_RST} st_t;

  st_t           st;
  logic [1:0]    op, ph;
  logic [2:0]    step;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr, cmd_a;
  logic [DW-1:0] data, cmd_d;
  logic [2:0]    rdv;
  logic          poll, rk, stage2, q6a, done_r, fail_r, last;
  logic          ev_pass, ev_fail, ev_s2;
  logic          unused_dq;

  wire is_prog = (op == 2'd0);
  wire exp7    = is_prog ? data[7] : 1'b1;
  wire wr_act  = (st == S_WR) || (st == S_RST);
  wire rd_act  = (st == S_RD) && (ph == 2'd0);

  assign unused_dq = ^f_dq_i;

  always_comb begin
    cmd_a = UNLK_A;
    cmd_d = DW'(8'hAA);
    last  = 1'b0;
    if (st == S_RST) begin
      cmd_a = '0;
      cmd_d = DW'(8'hF0);
    end else begin
      case (step)
        3'd0: ;
        3'd1: begin cmd_a = UNLK_B; cmd_d = DW'(8'h55); end
        3'd2: cmd_d = is_prog ? DW'(8'hA0) : DW'(8'h80);
        3'd3: if (is_prog) begin
                cmd_a = addr; cmd_d = data; last = 1'b1;
              end
        3'd4: begin cmd_a = UNLK_B; cmd_d = DW'(8'h55); end
        default: begin
          last = 1'b1;
          if (op[1]) cmd_d = DW'(8'h10);
          else begin cmd_a = addr; cmd_d = DW'(8'h30); end
        end
      endcase
    end
  end

  always_comb begin
    ev_pass = 1'b0;
    ev_fail = 1'b0;
    ev_s2   = 1'b0;
    if (!poll) begin
      if (rdv[2] == exp7) ev_pass = 1'b1;
      else if (stage2)    ev_fail = 1'b1;
      else if (rdv[0])    ev_s2   = 1'b1;
    end else if (rk) begin
      if (rdv[1] == q6a)  ev_pass = 1'b1;
      else if (stage2)    ev_fail = 1'b1;
      else if (rdv[0])    ev_s2   = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; op <= '0; ph <= '0; step <= '0; cnt <= '0;
      addr <= '0; data <= '0; rdv <= '0; poll <= 1'b0; rk <= 1'b0;
      stage2 <= 1'b0; q6a <= 1'b0; done_r <= 1'b0; fail_r <= 1'b0;
    end else begin
      done_r <= 1'b0;
      fail_r <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          op <= req_op; poll <= req_poll; addr <= req_addr; data <= req_data;
          step <= '0; ph <= '0; st <= S_WR;
        end
        S_WR, S_RST: case (ph)
          2'd0: begin ph <= 2'd1; cnt <= CW'(T_WL - 1); end
          2'd1: if (cnt == '0) ph <= 2'd2; else cnt <= cnt - 1'b1;
          2'd2: begin ph <= 2'd3; cnt <= CW'(T_GAP - 1); end
          default: begin
            if (cnt != '0) cnt <= cnt - 1'b1;
            else if (st == S_RST) begin
              st <= S_IDLE; ph <= '0; fail_r <= 1'b1;
            end else if (last) begin
              st <= S_RD; ph <= '0; cnt <= CW'(T_RD - 1); rk <= 1'b0; stage2 <= 1'b0;
            end else begin
              step <= step + 1'b1; ph <= '0;
            end
          end
        endcase
        S_RD: begin
          if (ph == 2'd0) begin
            if (cnt == '0) begin
              rdv <= {f_dq_i[7], f_dq_i[6], f_dq_i[5]};
              if (!rk) q6a <= f_dq_i[6];
              ph  <= 2'd3;
              cnt <= CW'(T_GAP - 1);
            end else cnt <= cnt - 1'b1;
          end else if (cnt != '0) cnt <= cnt - 1'b1;
          else begin
            ph  <= '0;
            cnt <= CW'(T_RD - 1);
            rk  <= poll ? ~rk : 1'b0;
            if (ev_pass) begin st <= S_IDLE; done_r <= 1'b1; end
            else if (ev_fail) st <= S_RST;
            else if (ev_s2) stage2 <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (st == S_IDLE);
  assign done      = done_r;
  assign fail      = fail_r;
  assign f_ce_n    = !((wr_act && ph != 2'd3) || rd_act);
  assign f_we_n    = !(wr_act && ph == 2'd1);
  assign f_oe_n    = !rd_act;
  assign f_dq_oe   = wr_act && ph != 2'd3;
  assign f_addr    = wr_act ? cmd_a : addr;
  assign f_dq_o    = cmd_d;
endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk #(
  parameter int AW = 22,
  parameter int DW = 8,
  parameter int T_WL = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          done,
  input logic          fail,
  input logic [AW-1:0] f_addr,
  input logic [DW-1:0] f_dq_o,
  input logic          f_dq_oe,
  input logic          f_ce_n,
  input logic          f_we_n,
  input logic          f_oe_n
);
  int wl;

  always_ff @(posedge clk) begin
    if (!rst_n) wl <= 0;
    else        wl <= f_we_n ? 0 : wl + 1;
  end

  assert_we_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !f_we_n |-> (!f_ce_n && f_oe_n && f_dq_oe));

  assert_we_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(f_we_n) |-> ($stable(f_addr) && $stable(f_dq_o)));

  assert_we_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_we_n) |-> (wl == T_WL));

  assert_no_contend_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !f_oe_n |-> !f_dq_oe);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (f_ce_n && f_we_n && f_oe_n));

  assert_one_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fail) |=> !(done || fail));

  assert_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));

  assert_end_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fail) |-> req_ready);
endmodule

bind flash_seq flash_seq_chk #(.AW(AW), .DW(DW), .T_WL(T_WL)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done), .fail(fail),
  .f_addr(f_addr), .f_dq_o(f_dq_o), .f_dq_oe(f_dq_oe),
  .f_ce_n(f_ce_n), .f_we_n(f_we_n), .f_oe_n(f_oe_n)
);

// File: tb/test_flash_seq.sv
module test_flash_seq;
  localparam int AW = 22;
  localparam int DW = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, req_valid, req_ready, req_poll, done, fail;
  logic [1:0] req_op;
  logic [AW-1:0] req_addr, f_addr;
  logic [DW-1:0] req_data, f_dq_o, f_dq_i;
  logic f_dq_oe, f_ce_n, f_we_n, f_oe_n;

  flash_seq i_flash_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_poll(req_poll), .req_addr(req_addr), .req_data(req_data),
    .done(done), .fail(fail), .f_addr(f_addr), .f_dq_o(f_dq_o), .f_dq_oe(f_dq_oe),
    .f_dq_i(f_dq_i), .f_ce_n(f_ce_n), .f_we_n(f_we_n), .f_oe_n(f_oe_n)
  );

  int total = 0;
  int bad = 0;

  int rd_n = 0;
  int busy_n = 0;
  int flt_n = 0;
  logic [7:0] expb = 8'h00;
  logic [AW+DW-1:0] wq[$];
  logic [AW-1:0] raq[$];

  function automatic logic [7:0] st_fn(int k);
    if (k < busy_n)              return {~expb[7], k[0], 1'b1 & 1'b0, 5'b0};
    else if (k < busy_n + flt_n) return {~expb[7], k[0], 1'b1, 5'b0};
    else                         return expb;
  endfunction

  assign f_dq_i = (rd_n == 0) ? 8'h00 : st_fn(rd_n - 1);

  always @(posedge f_we_n) if (!f_ce_n) wq.push_back({f_addr, f_dq_o});
  always @(negedge f_oe_n) begin rd_n = rd_n + 1; raq.push_back(f_addr); end

  task automatic chk(bit c, string rq, string what, int act, int exp);
    total++;
    if (!c) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic predict(bit poll, output int nr, output bit ok);
    int k = 0;
    bit s2 = 0;
    bit fin = 0;
    logic [7:0] a, b;
    ok = 0;
    while (!fin && k < 10000) begin
      if (!poll) begin
        a = st_fn(k); k++;
        if (a[7] == expb[7]) begin ok = 1; fin = 1; end
        else if (s2) fin = 1;
        else if (a[5]) s2 = 1;
      end else begin
        a = st_fn(k); b = st_fn(k + 1); k += 2;
        if (a[6] == b[6]) begin ok = 1; fin = 1; end
        else if (s2) fin = 1;
        else if (b[5]) s2 = 1;
      end
    end
    nr = k;
  endtask

  task automatic run_op(logic [1:0] op, bit poll, logic [AW-1:0] a, logic [7:0] d,
                        int busy, int flt, string rq, bit poke);
    logic [AW+DW-1:0] ew[$];
    int nr, dn, fl, cyc;
    bit ok;
    busy_n = busy; flt_n = flt;
    expb = (op == 2'd0) ? d : 8'hFF;
    rd_n = 0; wq.delete(); raq.delete();
    ew.push_back({AW'('h555), 8'hAA});
    ew.push_back({AW'('h2AA), 8'h55});
    if (op == 2'd0) begin
      ew.push_back({AW'('h555), 8'hA0});
      ew.push_back({a, d});
    end else begin
      ew.push_back({AW'('h555), 8'h80});
      ew.push_back({AW'('h555), 8'hAA});
      ew.push_back({AW'('h2AA), 8'h55});
      if (op[1]) ew.push_back({AW'('h555), 8'h10});
      else       ew.push_back({a, 8'h30});
    end
    predict(poll, nr, ok);
    if (!ok) ew.push_back({AW'(0), 8'hF0});   // R10 reset write

    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready before request", req_ready, 1);
    req_valid = 1'b1; req_op = op; req_poll = poll; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R1", "ready after accept", req_ready, 0);
    dn = 0; fl = 0; cyc = 0;
    while (dn + fl == 0 && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (done) dn++;
      if (fail) fl++;
      // R1: cycle-by-cycle reference of ready
      if (req_ready != ((dn + fl) != 0))
        chk(1'b0, "R1", "ready per cycle", req_ready, (dn + fl) != 0);
      if (poke && cyc == 6) begin
        req_valid = 1'b1; req_op = 2'd0; req_addr = AW'('h1234); req_data = 8'h00;
      end else if (poke && cyc == 9) req_valid = 1'b0;
    end
    repeat (6) begin
      @(negedge clk);
      if (done) dn++;
      if (fail) fl++;
    end
    chk(dn + fl == 1, "R11", "result pulse count", dn + fl, 1);
    chk(dn == int'(ok), {rq, " R11"}, "done/fail outcome", dn, int'(ok));
    chk(rd_n == nr, rq, "status read count", rd_n, nr);
    chk(wq.size() == ew.size(), rq, "write count", wq.size(), ew.size());
    for (int i = 0; i < ew.size() && i < wq.size(); i++)
      chk(wq[i] == ew[i], rq, $sformatf("write %0d addr/data", i), int'(wq[i]), int'(ew[i]));
    for (int i = 0; i < raq.size(); i++)
      chk(raq[i] == a, "R6", "status read address", int'(raq[i]), int'(a));
    chk(req_ready == 1'b1, "R1", "idle after end", req_ready, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_poll = 1'b0;
    req_addr = '0; req_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && f_ce_n && f_we_n && f_oe_n && !f_dq_oe, "R1", "reset bus state",
        {req_ready, f_ce_n, f_we_n, f_oe_n, f_dq_oe}, 5'b11110);
    chk(!done && !fail, "R11", "reset pulses", {done, fail}, 0);

    run_op(2'd0, 1'b0, AW'('h01A2B3), 8'h5A, 3, 0,    "R2 R6", 1'b0);
    run_op(2'd0, 1'b0, AW'('h000040), 8'hC3, 0, 0,    "R2 R6", 1'b0);
    run_op(2'd1, 1'b1, AW'('h230000), 8'h00, 5, 0,    "R4 R8", 1'b0);
    run_op(2'd2, 1'b0, AW'('h000000), 8'h00, 2, 0,    "R3 R6", 1'b0);
    run_op(2'd0, 1'b0, AW'('h3FFFFF), 8'h15, 2, 1,    "R7", 1'b0);
    run_op(2'd0, 1'b0, AW'('h100200), 8'h81, 2, 1000, "R7 R10", 1'b0);
    run_op(2'd1, 1'b1, AW'('h150000), 8'h00, 4, 2,    "R9", 1'b0);
    run_op(2'd2, 1'b1, AW'('h000000), 8'h00, 1, 1000, "R9 R10", 1'b0);
    run_op(2'd0, 1'b1, AW'('h0ABCDE), 8'h3C, 6, 0,    "R1 R8", 1'b1);
    run_op(2'd3, 1'b0, AW'('h000000), 8'h00, 1, 0,    "R3", 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule